// File: doc/BRIEF.md
# Rotation-Invariant Canonical Form Unit

This block takes an N-bit pattern and returns one fixed representative of the set of words that differ from it only by a circular rotation. The representative is the numerically largest of the N left rotations of the input. Any rotation of a pattern therefore yields the same output word. The block also reports the left-rotation amount that produced that word. When several amounts give the same maximum, the smallest one is reported.

The datapath is fully pipelined and accepts one pattern on every clock. All N rotations are formed at once by rewiring. A balanced binary tree of compare-and-select stages then reduces them, with one register per tree level. A valid flag travels alongside the data. There is no iteration and no lookup table, so the output rate is independent of N. Only the latency grows, logarithmically.

Top module: `rot_canon`

## Requirements
- R1: When `valid_o` is high, `canon_o` equals the largest value among the N left rotations of the pattern that was presented with `valid_i` high ceil(log2 N) cycles earlier.
- R2: Two input patterns that are circular rotations of one another produce the same `canon_o`.
- R3: `rot_o` is the smallest k in 0..N-1 such that the left rotation of the input by k equals `canon_o`. For example, for N=8 the input 01010101 gives rot 1. `rot_o` is always below N.
- R4: An all-zero input gives an all-zero `canon_o` with `rot_o` 0. An all-ones input gives all ones with `rot_o` 0.
- R5: `valid_o` equals `valid_i` delayed by exactly ceil(log2 N) clocks, and a new pattern is accepted on every clock.
- R6: While `rst_n` is low at a rising clock edge, the block clears `valid_o`, `canon_o` and `rot_o` to zero on that edge.
- R7: A left rotation by k moves input bit i to bit (i+k) mod N. For N=11, 01100011010 gives 11010011000 with `rot_o` 6. For N=8, 00000011 gives 11000000 with `rot_o` 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Qualifies `pat_i` in this cycle |
| pat_i | input | N | Pattern to be reduced to canonical form |
| valid_o | output | 1 | Qualifies `canon_o` and `rot_o` |
| canon_o | output | N | Largest rotation of the pattern |
| rot_o | output | ceil(log2 N) | Smallest left-rotation amount that yields `canon_o` |

## Verification
For an 8-bit instance, every one of the 256 patterns is streamed back to back, with idle gaps in the stream. Each result is compared against a maximum over rotations computed in the bench. The recorded outputs are then compared between each pattern and its one-step rotation, which checks invariance directly rather than through the reference. Periodic patterns such as 01010101 separate the smallest-amount tie rule from any other choice among equal rotations. The all-zero and all-ones words give the ties in which every rotation is equal.

An 11-bit instance is driven with the worked example and all its rotations, followed by a pseudo-random stream. Because 11 is not a power of two, these runs exercise the padded inputs of the tree, which must never win.

// File: rtl/rot_canon_pkg.sv
// Package rot_canon_pkg
// Shared helper for the canonical-form unit: elaboration-time width math.
// Assumes arguments are positive integers known at elaboration.
package rot_canon_pkg;

    // Smallest r with 2**r >= n, but never less than 1.
    function automatic int unsigned log2_up(input int unsigned n);
        int unsigned r;
        r = 1;
        while ((32'd1 << r) < n) r = r + 1;
        return r;
    endfunction

endpackage

// File: rtl/rot_canon_rotgen.sv
// Module rot_canon_rotgen
// Forms every left rotation of the input pattern by pure wiring and pads
// the set up to a power of two for the reduction tree.
// Assumes: N >= 2 and P >= N. Entry k holds the rotation by k and carries
// index k. Padded entries hold zero with an index >= N; because they sit to
// the right of every real entry, the tie rule keeps them from ever winning.
module rot_canon_rotgen #(
    parameter int N  = 16,
    parameter int AW = 4,
    parameter int P  = 16
) (
    input  logic [N-1:0]            pat_i,
    output logic [P-1:0][N-1:0]     val_o,
    output logic [P-1:0][AW-1:0]    idx_o
);

    // One wired rotation (or zero pad) per tree input.
    for (genvar k = 0; k < P; k++) begin : g_rot
        if (k == 0) begin : g_id
            assign val_o[k] = pat_i;
        end else if (k < N) begin : g_real
            assign val_o[k] = {pat_i[N-1-k:0], pat_i[N-1:N-k]};
        end else begin : g_pad
            assign val_o[k] = '0;
        end
        assign idx_o[k] = AW'(k);
    end

endmodule

// File: rtl/rot_canon_level.sv
// Module rot_canon_level
// One registered level of the max-reduction tree: halves the candidate
// count by keeping, from each adjacent pair, the larger value, or on a
// tie the one with the smaller rotation index.
// Assumes: CNT is even; entry 2j always carries a smaller index than 2j+1.
module rot_canon_level #(
    parameter int N   = 16,
    parameter int AW  = 4,
    parameter int CNT = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         valid_i,
    input  logic [CNT-1:0][N-1:0]        val_i,
    input  logic [CNT-1:0][AW-1:0]       idx_i,
    output logic                         valid_o,
    output logic [CNT/2-1:0][N-1:0]      val_o,
    output logic [CNT/2-1:0][AW-1:0]     idx_o
);

    localparam int HALF = CNT / 2;

    logic [HALF-1:0][N-1:0]  win_val;
    logic [HALF-1:0][AW-1:0] win_idx;

    // Pairwise compare-and-select for this level.
    always_comb begin
        for (int j = 0; j < HALF; j++) begin
            if ((val_i[2*j] > val_i[2*j+1]) ||
                ((val_i[2*j] == val_i[2*j+1]) && (idx_i[2*j] <= idx_i[2*j+1]))) begin
                win_val[j] = val_i[2*j];
                win_idx[j] = idx_i[2*j];
            end else begin
                win_val[j] = val_i[2*j+1];
                win_idx[j] = idx_i[2*j+1];
            end
        end
    end

    // Level register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            val_o   <= '0;
            idx_o   <= '0;
        end else begin
            valid_o <= valid_i;
            val_o   <= win_val;
            idx_o   <= win_idx;
        end
    end

    // R5: the valid flag advances exactly one stage per clock.
    a_r5_valid_step: assert property (@(posedge clk) disable iff (!rst_n)
        valid_i |=> valid_o);
    a_r5_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !valid_o);

    for (genvar j = 0; j < HALF; j++) begin : g_chk
        // R1: the kept candidate is no smaller than either contender.
        a_r1_keeps_max: assert property (@(posedge clk) disable iff (!rst_n)
            valid_i |=> ((val_o[j] >= $past(val_i[2*j])) &&
                         (val_o[j] >= $past(val_i[2*j+1]))));
        // R3: on equal values the smaller-index contender survives.
        a_r3_tie_low_index: assert property (@(posedge clk) disable iff (!rst_n)
            (valid_i && (val_i[2*j] == val_i[2*j+1])) |=>
                (idx_o[j] == $past(idx_i[2*j])));
    end

endmodule

// File: rtl/rot_canon.sv
// Module rot_canon (top)
// Maps an N-bit pattern to the largest of its circular left rotations and
// reports the smallest rotation amount giving it. One pattern per clock,
// latency LV = ceil(log2 N) clocks, valid flag delayed alongside.
// Assumes: N >= 2; rst_n is synchronous and active low.
module rot_canon
    import rot_canon_pkg::*;
#(
    parameter int N = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          valid_i,
    input  logic [N-1:0]                  pat_i,
    output logic                          valid_o,
    output logic [N-1:0]                  canon_o,
    output logic [log2_up(N)-1:0]         rot_o
);

    localparam int LV  = log2_up(N);
    localparam int AW  = LV;
    localparam int P   = 1 << LV;
    localparam int TOT = 2 * P - 1;

    // Tree storage laid out level after level: level lv starts at
    // 2P - (2P >> lv) and holds P >> lv candidates.
    logic [TOT-1:0][N-1:0]  tv;
    logic [TOT-1:0][AW-1:0] ti;
    logic [LV:0]            vchain;

    assign vchain[0] = valid_i;

    rot_canon_rotgen #(.N(N), .AW(AW), .P(P)) u_rotgen (
        .pat_i (pat_i),
        .val_o (tv[P-1:0]),
        .idx_o (ti[P-1:0])
    );

    // One registered compare level per tree stage.
    for (genvar lv = 0; lv < LV; lv++) begin : g_lvl
        localparam int CNT  = P >> lv;
        localparam int OFFI = 2 * P - ((2 * P) >> lv);
        localparam int OFFO = OFFI + CNT;
        rot_canon_level #(.N(N), .AW(AW), .CNT(CNT)) u_level (
            .clk     (clk),
            .rst_n   (rst_n),
            .valid_i (vchain[lv]),
            .val_i   (tv[OFFI+CNT-1:OFFI]),
            .idx_i   (ti[OFFI+CNT-1:OFFI]),
            .valid_o (vchain[lv+1]),
            .val_o   (tv[OFFO+CNT/2-1:OFFO]),
            .idx_o   (ti[OFFO+CNT/2-1:OFFO])
        );
    end

    assign valid_o = vchain[LV];
    assign canon_o = tv[TOT-1];
    assign rot_o   = ti[TOT-1];

    // R3: a reported rotation amount is always a real rotation.
    a_r3_rot_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (int'(rot_o) < N));

    // R6: reset leaves the output stage empty and zero.
    a_r6_reset_clear: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && (canon_o == '0) && (rot_o == '0)));

endmodule

// File: tb/rot_canon_bench.sv
// Bench for rot_canon: exhaustive 8-bit sweep plus an 11-bit stream,
// reference maxima computed by loops over rotations.
module rot_canon_bench;

    localparam int NCYC = 330;
    localparam int L8   = 3;
    localparam int L11  = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        v8_i, v8_o, v11_i, v11_o;
    logic [7:0]  p8, c8;
    logic [2:0]  r8;
    logic [10:0] p11, c11;
    logic [3:0]  r11;

    rot_canon #(.N(8)) u_rot_canon (
        .clk(clk), .rst_n(rst_n), .valid_i(v8_i), .pat_i(p8),
        .valid_o(v8_o), .canon_o(c8), .rot_o(r8));

    rot_canon #(.N(11)) u_rot_canon_w11 (
        .clk(clk), .rst_n(rst_n), .valid_i(v11_i), .pat_i(p11),
        .valid_o(v11_o), .canon_o(c11), .rot_o(r11));

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [7:0]  h8  [0:NCYC];
    bit          hv8 [0:NCYC];
    logic [10:0] h11 [0:NCYC];
    bit          hv11[0:NCYC];
    logic [7:0]  got8  [0:255];
    logic [2:0]  gotr8 [0:255];

    function automatic logic [15:0] rotl(input logic [15:0] x, input int k, input int n);
        logic [15:0] y;
        y = '0;
        for (int i = 0; i < n; i++) y[(i + k) % n] = x[i];
        return y;
    endfunction

    task automatic ref_canon(input logic [15:0] x, input int n,
                             output logic [15:0] best, output int bk);
        best = rotl(x, 0, n);
        bk   = 0;
        for (int k = 1; k < n; k++) begin
            if (rotl(x, k, n) > best) begin
                best = rotl(x, k, n);
                bk   = k;
            end
        end
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Watchdog: a hung run is a failed check and still reports.
    initial begin
        #(20 * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [15:0] eb;
        int          ek;
        int          q8;
        logic [15:0] lfsr;
        v8_i = 0; v11_i = 0; p8 = '0; p11 = '0;
        q8 = 0; lfsr = 16'hACE1;

        repeat (3) @(negedge clk);
        // R6: outputs cleared while in reset.
        chk("R6 valid8", 16'(v8_o), 16'h0);
        chk("R6 canon8", 16'(c8), 16'h0);
        chk("R6 rot8", 16'(r8), 16'h0);
        chk("R6 valid11", 16'(v11_o), 16'h0);
        chk("R6 canon11", 16'(c11), 16'h0);
        rst_n = 1'b1;

        for (int c = 0; c < NCYC; c++) begin
            @(negedge clk);
            if (c >= L8) begin
                int ix;
                ix = c - L8;
                chk("R5 valid8", 16'(v8_o), 16'(hv8[ix]));
                if (hv8[ix]) begin
                    ref_canon(16'(h8[ix]), 8, eb, ek);
                    chk("R1 canon8", 16'(c8), eb);
                    chk("R3 rot8", 16'(r8), 16'(ek));
                    got8[h8[ix]]  = c8;
                    gotr8[h8[ix]] = r8;
                end
            end
            if (c >= L11) begin
                int ix;
                ix = c - L11;
                chk("R5 valid11", 16'(v11_o), 16'(hv11[ix]));
                if (hv11[ix]) begin
                    ref_canon(16'(h11[ix]), 11, eb, ek);
                    chk("R1 canon11", 16'(c11), eb);
                    chk("R3 rot11", 16'(r11), 16'(ek));
                    if (h11[ix] == 11'b01100011010) begin
                        chk("R7 canon11 example", 16'(c11), 16'(11'b11010011000));
                        chk("R7 rot11 example", 16'(r11), 16'd6);
                    end
                    if (h11[ix] == 11'h000 || h11[ix] == 11'h7FF) begin
                        chk("R4 canon11 uniform", 16'(c11), 16'(h11[ix]));
                        chk("R4 rot11 uniform", 16'(r11), 16'd0);
                    end
                end
            end
            // Drive the 8-bit sweep with periodic idle gaps.
            if (q8 < 256 && (c % 9) != 4) begin
                v8_i = 1'b1; p8 = 8'(q8); q8++;
            end else begin
                v8_i = 1'b0; p8 = 8'hA5;
            end
            h8[c] = p8; hv8[c] = v8_i;
            // Drive the 11-bit stream: example, its rotations, uniforms, then random.
            if ((c % 13) == 5) begin
                v11_i = 1'b0; p11 = 11'h5A5;
            end else begin
                v11_i = 1'b1;
                if (c < 11)       p11 = 11'(rotl(16'(11'b01100011010), c, 11));
                else if (c == 11) p11 = 11'h000;
                else if (c == 12) p11 = 11'h7FF;
                else begin
                    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
                    p11  = lfsr[10:0];
                end
            end
            h11[c] = p11; hv11[c] = v11_i;
        end

        // R2: recorded outputs agree between each pattern and its rotation.
        for (int p = 0; p < 256; p++)
            chk("R2 invariance8", 16'(got8[p]), 16'(got8[rotl(16'(p), 1, 8)]));
        chk("R4 zero8", 16'(got8[8'h00]), 16'h00);
        chk("R4 zero8 rot", 16'(gotr8[8'h00]), 16'h0);
        chk("R4 ones8", 16'(got8[8'hFF]), 16'hFF);
        chk("R4 ones8 rot", 16'(gotr8[8'hFF]), 16'h0);
        chk("R7 canon8 00000011", 16'(got8[8'h03]), 16'hC0);
        chk("R7 rot8 00000011", 16'(gotr8[8'h03]), 16'd6);
        chk("R3 tie 01010101", 16'(gotr8[8'h55]), 16'd1);
        chk("R2 example 1001", 16'(got8[8'h09]), 16'(got8[8'h90]));

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

endmodule